// File: doc/BRIEF.md
# Received Payload Length Capture

This block measures how many payload bits each received packet carried. A running counter advances by one on every cycle in which the payload-bit strobe is high. When the start/sync detector reports the next packet, the counter's value is committed to a status word and the counter restarts from zero. Because the commit happens at the next packet's start rather than at an end-of-message event, packets that end without such an event are still measured. Examples are a packet with a rejected identifier or a packet that lost sync.

The status word is 10 bits wide and is presented as two fields. One is a low byte and the other is a 2-bit high part, which a register layer places in the upper two bits of a separate status byte. The counter stops at its maximum value of 1023 and does not wrap. A FIFO-initialise pulse clears both the counter and the status word.

Top module: `paylen_capture`

## Requirements
- R1: While `rst_n` is low, both status fields read 0 and the running count is 0. After release, the first packet is measured from zero.
- R2: Each cycle with `bit_vld` high and neither `fifo_init` nor `sop_det` high raises the running count by exactly one. Cycles without a strobe leave the count unchanged.
- R3: The running count saturates at 1023 (all ones) and never wraps. A packet of more than 1023 bits is reported as 1023.
- R4: A cycle with `sop_det` high and `fifo_init` low copies the running count into the status word, visible from the next cycle. `len_lo` carries count bits 7:0 and `len_hi` carries count bits 9:8.
- R5: `fifo_init` clears the status word and the running count on the next edge. It takes priority over a `sop_det` in the same cycle.
- R6: Between start detects and initialisations, the status word holds its value whatever the payload strobes do. No end-of-packet event is needed for a length to be published.
- R7: A payload strobe in the same cycle as `sop_det` is counted neither in the packet being closed nor in the packet being opened.
- R8: The running count restarts at 0 after every `sop_det`, so each published length covers only the bits since the previous start detect or initialisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fifo_init | input | 1 | FIFO initialise: clears count and status |
| sop_det | input | 1 | Start/sync detected for a new packet |
| bit_vld | input | 1 | One payload bit received this cycle |
| len_lo | output | 8 | Published length, bits 7:0 |
| len_hi | output | 2 | Published length, bits 9:8 |

## Verification
The bench builds the block with its default widths: a 10-bit count split into an 8-bit low field and a 2-bit high part. With these widths a single packet of 1024 or more strobes, about 1100 cycles, reaches the saturation ceiling. The lengths 255, 256 and 770 exercise the carry into the high part and the split of a value across the two fields. Narrower parameters would reach saturation sooner but would not test the field boundary the register layer depends on, so the defaults were kept.

// File: rtl/paylen_pkg.sv
package paylen_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_INC   = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/paylen_rst_sync.sv
module paylen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/paylen_counter.sv
module paylen_counter
  import paylen_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  cnt_act_e         act;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // clear wins over increment; increment stops at the ceiling
  always_comb begin
    if (clr) begin
      act = ACT_CLEAR;
    end else if (inc && (cnt_q != CNT_MAX)) begin
      act = ACT_INC;
    end else begin
      act = ACT_HOLD;
    end
  end

  always_comb begin
    case (act)
      ACT_CLEAR: cnt_d = '0;
      ACT_INC:   cnt_d = cnt_q + 1'b1;
      default:   cnt_d = cnt_q;
    endcase
  end

  assign cnt_en = (act != ACT_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/paylen_status.sv
module paylen_status #(
  parameter int CNT_W = 10,
  parameter int LO_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init,
  input  logic                  cap,
  input  logic [CNT_W-1:0]      cnt,
  output logic [LO_W-1:0]       len_lo,
  output logic [CNT_W-LO_W-1:0] len_hi
);
  localparam int HI_W = CNT_W - LO_W;

  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] len_d;
  logic             len_en;

  assign len_en = init | cap;

  always_comb begin
    if (init) begin
      len_d = '0;
    end else begin
      len_d = cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_en) begin
      len_q <= len_d;
    end
  end

  assign len_lo = len_q[LO_W-1:0];
  assign len_hi = len_q[LO_W +: HI_W];
endmodule

// File: rtl/paylen_capture.sv
module paylen_capture #(
  parameter int CNT_W = 10,
  parameter int LO_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fifo_init,
  input  logic                  sop_det,
  input  logic                  bit_vld,
  output logic [LO_W-1:0]       len_lo,
  output logic [CNT_W-LO_W-1:0] len_hi
);
  logic             srst_n;
  logic [CNT_W-1:0] run_cnt;
  logic             cnt_clr;
  logic             cap_en;

  assign cnt_clr = fifo_init | sop_det;
  assign cap_en  = sop_det & ~fifo_init;

  paylen_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  paylen_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (cnt_clr),
    .inc   (bit_vld),
    .cnt_q (run_cnt)
  );

  paylen_status #(.CNT_W(CNT_W), .LO_W(LO_W)) u_status (
    .clk    (clk),
    .rst_n  (srst_n),
    .init   (fifo_init),
    .cap    (cap_en),
    .cnt    (run_cnt),
    .len_lo (len_lo),
    .len_hi (len_hi)
  );
endmodule

// File: rtl/paylen_capture_chk.sv
module paylen_capture_chk #(
  parameter int CNT_W = 10,
  parameter int LO_W  = 8
) (
  input logic                  clk,
  input logic                  srst_n,
  input logic                  fifo_init,
  input logic                  sop_det,
  input logic                  bit_vld,
  input logic [CNT_W-1:0]      run_cnt,
  input logic [LO_W-1:0]       len_lo,
  input logic [CNT_W-LO_W-1:0] len_hi
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] status;
  assign status = {len_hi, len_lo};

  p_count_step_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (bit_vld && !sop_det && !fifo_init && run_cnt != CNT_MAX)
      |=> run_cnt == $past(run_cnt) + 1'b1);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (!bit_vld && !sop_det && !fifo_init) |=> $stable(run_cnt));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (run_cnt == CNT_MAX && !sop_det && !fifo_init) |=> run_cnt == CNT_MAX);

  p_capture_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (sop_det && !fifo_init) |=> status == $past(run_cnt));

  p_init_clear_r5: assert property (@(posedge clk) disable iff (!srst_n)
    fifo_init |=> (status == '0 && run_cnt == '0));

  p_status_hold_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (!sop_det && !fifo_init) |=> $stable(status));

  p_restart_r8: assert property (@(posedge clk) disable iff (!srst_n)
    sop_det |=> run_cnt == '0);
endmodule

bind paylen_capture paylen_capture_chk #(.CNT_W(CNT_W), .LO_W(LO_W)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .fifo_init (fifo_init),
  .sop_det   (sop_det),
  .bit_vld   (bit_vld),
  .run_cnt   (run_cnt),
  .len_lo    (len_lo),
  .len_hi    (len_hi)
);

// File: tb/paylen_capture_tb.sv
module paylen_capture_tb;
  localparam int CNT_W = 10;
  localparam int LO_W  = 8;
  localparam int NV    = 10;

  // {strobes[10:0], coincident strobe on start detect, expected length[10:0]}
  localparam logic [22:0] VEC [NV] = '{
    {11'd0,    1'b0, 11'd0},
    {11'd5,    1'b0, 11'd5},
    {11'd255,  1'b1, 11'd255},
    {11'd256,  1'b0, 11'd256},
    {11'd1,    1'b1, 11'd1},
    {11'd770,  1'b0, 11'd770},
    {11'd1023, 1'b0, 11'd1023},
    {11'd1024, 1'b1, 11'd1023},
    {11'd1100, 1'b0, 11'd1023},
    {11'd300,  1'b0, 11'd300}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             fifo_init;
  logic             sop_det;
  logic             bit_vld;
  logic [LO_W-1:0]  len_lo;
  logic [1:0]       len_hi;
  int               n_chk = 0;
  int               n_bad = 0;

  always #2 clk = ~clk;

  paylen_capture #(.CNT_W(CNT_W), .LO_W(LO_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_init (fifo_init),
    .sop_det   (sop_det),
    .bit_vld   (bit_vld),
    .len_lo    (len_lo),
    .len_hi    (len_hi)
  );

  task automatic cyc(input logic i, input logic s, input logic b);
    @(negedge clk);
    fifo_init = i;
    sop_det   = s;
    bit_vld   = b;
  endtask

  task automatic chk(input string req, input int exp);
    int act;
    act = int'({len_hi, len_lo});
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic bits(input int n);
    for (int k = 0; k < n; k++) begin
      cyc(1'b0, 1'b0, 1'b1);
      if (k % 7 == 3) cyc(1'b0, 1'b0, 1'b0);
    end
  endtask

  // start detect, then idle so the capture edge has passed
  task automatic sop(input logic coinc);
    cyc(1'b0, 1'b1, coinc);
    cyc(1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; fifo_init = 1'b0; sop_det = 1'b0; bit_vld = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 status in reset", 0);
    rst_n = 1'b1;
    repeat (3) cyc(1'b0, 1'b0, 1'b0);
    chk("R1 status after release", 0);

    // R1/R2: first packet measured from zero
    bits(3);
    sop(1'b0);
    chk("R1 R2 first packet", 3);

    // vector table: R2 R3 R4 R7 R8
    for (int v = 0; v < NV; v++) begin
      bits(int'(VEC[v][22:12]));
      sop(VEC[v][11]);
      chk($sformatf("R3 R4 R7 R8 vector %0d", v), int'(VEC[v][10:0]));
    end

    // R6: status holds while strobes arrive without start detect
    bits(20);
    chk("R6 hold during strobes", 300);
    repeat (5) cyc(1'b0, 1'b0, 1'b0);
    chk("R6 hold while idle", 300);

    // R5: init clears status and count
    cyc(1'b1, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R5 init clears status", 0);
    bits(7);
    sop(1'b0);
    chk("R5 count restarted by init", 7);

    // R5: init wins over simultaneous start detect
    bits(9);
    cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R5 init priority over start", 0);
    bits(4);
    sop(1'b0);
    chk("R5 count cleared on init+start", 4);

    // R8: back-to-back start detects give zero length
    sop(1'b0);
    chk("R8 empty packet", 0);

    // R1: asynchronous reset mid-run
    bits(12);
    sop(1'b0);
    chk("R4 before reset", 12);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears status", 0);
    rst_n = 1'b1;
    repeat (3) cyc(1'b0, 1'b0, 1'b0);
    bits(2);
    sop(1'b0);
    chk("R1 count zero after reset", 2);

    finish_run();
  end
endmodule